// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block watches over software by counting up from zero and raising a reset request when the count reaches a programmed limit. Software keeps the system alive by writing a two-word service key to the key register before the limit is reached. The count source is either every bus clock or a 1 kHz tick supplied from outside. When the tick is selected, the limit equals the timeout in milliseconds. The limit and the optional window bound are held with their two bytes swapped (big-endian), so software must swap the value it writes.

The control registers are guarded. A two-word unlock key opens a short window in which configuration writes take effect. Outside that window the writes are dropped. If software clears the update-allow bit, later unlocks no longer open the window, and the configuration stays fixed until the next reset. Any misuse of the key register raises the reset request at once, even while the watchdog is disabled. Misuse means a wrong value, a write narrower than 16 bits, a second word that comes too late, or a service performed before the window bound. The request stays high until the block itself is reset.

Register map (3-bit word address): 0 = control (bit 0 enable, bit 1 update-allow, bit 2 count source, 1 = tick), 1 = status (bit 0 timeout flag), 2 = limit, 3 = window bound, 4 = key (reads zero).

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the reset request is low and the registers read as follows: control 0x0002 (update-allow set, disabled, bus clock source), limit 0xFFFF, window 0x0000, status 0x0000.
- R2: Writes to control, limit or window are ignored unless an unlock is open. An unlock is the full-width key word 0x20C5 followed by 0x28D9.
- R3: After an unlock, configuration writes take effect for CFG_OPEN (128) bus clocks. A write made after that is ignored.
- R4: Once the update-allow bit (control bit 1) is written as 0, a later correct unlock opens no window and raises no reset request. Configuration writes then stay ignored.
- R5: The effective limit is the limit register with its bytes swapped. While the watchdog is enabled and counts bus clocks, the reset request rises in the (N+1)th cycle after the enabling write, where N is the effective limit. Writing an unswapped small value gives a limit 256 times larger.
- R6: With control bit 2 set, the count advances only on cycles where tick_1k is high.
- R7: The service key is the full-width word 0x02A6 followed by 0xB480. It clears the count to zero, so the timeout restarts from that write.
- R8: A full-width key word that does not fit the sequence raises the reset request on the next clock edge.
- R9: A key write with only one byte lane enabled raises the reset request on the next clock edge, even while the watchdog is disabled.
- R10: If the second key word does not arrive within KEY_GAP (16) bus clocks of the first, the reset request rises.
- R11: When the byte-swapped window register is non-zero, a service that completes while the count is below it raises the reset request. A window value of 0 accepts a service at any count.
- R12: Status bit 0 is set when the count reaches the limit. Writing a 1 to it clears it, and this works without an unlock.
- R13: Once raised, the reset request stays high until rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz, used as the alternative count source |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_be | input | 2 | Byte lane enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| wdog_rst_req | output | 1 | Sticky reset request |

## Verification
Two kinds of internal fault show up at the ports. A wrong count or a wrong byte order moves the edge of wdog_rst_req, so the bench samples that edge a few cycles before and after the expected cycle. A key sequencer stuck in the wrong state either raises the request on the very next edge or swallows a fault that should have raised it, so each key scenario checks wdog_rst_req straight after the write that decides it. A configuration gate that is open at the wrong time appears as a register read-back that differs from the expected value, directly after the write.

// File: rtl/wdk_pkg.sv
// Package: shared constants, key words and the key sequencer state type
// for the keyed watchdog. Assumes a 16-bit data bus with 3-bit word addresses.
package wdk_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_TOV  = 3'd2;
    localparam logic [ADDR_W-1:0] A_WIN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd4;

    localparam logic [15:0] UNLOCK_W1  = 16'h20C5;
    localparam logic [15:0] UNLOCK_W2  = 16'h28D9;
    localparam logic [15:0] SERVICE_W1 = 16'h02A6;
    localparam logic [15:0] SERVICE_W2 = 16'hB480;

    localparam int CTL_EN  = 0;
    localparam int CTL_UPD = 1;
    localparam int CTL_CLK = 2;

    typedef enum logic [1:0] {KS_IDLE, KS_UNLOCK, KS_SERVICE} key_state_e;

    // Swap the two bytes of a big-endian register value
    function automatic logic [15:0] swap16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction
endpackage

// File: rtl/wdk_key_seq.sv
// Key sequencer: decodes writes to the key register into unlock and service
// pulses, and flags any malformed, narrow, wrong or late key word.
// Assumes key_wr is high only for a write to the key address with a byte lane set.
module wdk_key_seq
    import wdk_pkg::*;
#(
    parameter int KEY_GAP = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [1:0]  key_be,
    input  logic [15:0] key_data,
    input  logic        early_i,
    output logic        unlock_o,
    output logic        service_o,
    output logic        fault_o
);
    localparam int GAP_W = $clog2(KEY_GAP + 1);

    key_state_e        state_q, state_d;
    logic [GAP_W-1:0]  gap_q, gap_d;
    logic              full_w;

    assign full_w = (key_be == 2'b11);

    // Next-state decode of the key sequence and fault detection
    always_comb begin
        state_d   = state_q;
        gap_d     = gap_q;
        unlock_o  = 1'b0;
        service_o = 1'b0;
        fault_o   = 1'b0;
        case (state_q)
            KS_IDLE: begin
                if (key_wr) begin
                    if (!full_w) begin
                        fault_o = 1'b1;
                    end else if (key_data == UNLOCK_W1) begin
                        state_d = KS_UNLOCK;
                        gap_d   = '0;
                    end else if (key_data == SERVICE_W1) begin
                        state_d = KS_SERVICE;
                        gap_d   = '0;
                    end else begin
                        fault_o = 1'b1;
                    end
                end
            end
            default: begin
                if (key_wr) begin
                    state_d = KS_IDLE;
                    gap_d   = '0;
                    if (!full_w) begin
                        fault_o = 1'b1;
                    end else if (state_q == KS_UNLOCK && key_data == UNLOCK_W2) begin
                        unlock_o = 1'b1;
                    end else if (state_q == KS_SERVICE && key_data == SERVICE_W2) begin
                        if (early_i) fault_o = 1'b1;
                        else         service_o = 1'b1;
                    end else begin
                        fault_o = 1'b1;
                    end
                end else if (gap_q == GAP_W'(KEY_GAP - 1)) begin
                    fault_o = 1'b1;
                    state_d = KS_IDLE;
                    gap_d   = '0;
                end else begin
                    gap_d = gap_q + 1'b1;
                end
            end
        endcase
    end

    // Register the sequence state and the inter-word gap count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // R10
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < GAP_W'(KEY_GAP));

    // R10
    gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_IDLE) |-> (gap_q == '0));
endmodule

// File: rtl/wdk_cfg_regs.sv
// Configuration registers: control, limit, window and timeout flag, with
// the unlock-window gate and the update-allow lock. Assumes unlock_i is
// a one-cycle pulse from the key sequencer.
module wdk_cfg_regs
    import wdk_pkg::*;
#(
    parameter int CFG_OPEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        be,
    input  logic [15:0]       wdata,
    input  logic              unlock_i,
    input  logic              expire_i,
    output logic              ctl_en,
    output logic              ctl_upd,
    output logic              ctl_clk,
    output logic [15:0]       tov_raw,
    output logic [15:0]       win_raw,
    output logic              tmo_flag
);
    localparam int OPEN_W = $clog2(CFG_OPEN + 1);

    logic [OPEN_W-1:0] open_q;
    logic              cfg_we;
    logic              expire_q;
    logic              flag_clr;

    assign cfg_we   = wr && (open_q != '0) && ctl_upd;
    assign flag_clr = wr && (addr == A_STAT) && be[0] && wdata[0];

    // Count down the configuration window opened by an unlock
    always_ff @(posedge clk) begin
        if (!rst_n)                  open_q <= '0;
        else if (unlock_i && ctl_upd) open_q <= OPEN_W'(CFG_OPEN);
        else if (open_q != '0)       open_q <= open_q - 1'b1;
    end

    // Accept gated configuration writes byte lane by byte lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en  <= 1'b0;
            ctl_upd <= 1'b1;
            ctl_clk <= 1'b0;
            tov_raw <= 16'hFFFF;
            win_raw <= 16'h0000;
        end else if (cfg_we) begin
            case (addr)
                A_CTRL: begin
                    if (be[0]) begin
                        ctl_en  <= wdata[CTL_EN];
                        ctl_upd <= wdata[CTL_UPD];
                        ctl_clk <= wdata[CTL_CLK];
                    end
                end
                A_TOV: begin
                    if (be[0]) tov_raw[7:0]  <= wdata[7:0];
                    if (be[1]) tov_raw[15:8] <= wdata[15:8];
                end
                A_WIN: begin
                    if (be[0]) win_raw[7:0]  <= wdata[7:0];
                    if (be[1]) win_raw[15:8] <= wdata[15:8];
                end
                default: ;
            endcase
        end
    end

    // Set the timeout flag on the rising edge of expiry, clear on write-one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire_q <= 1'b0;
            tmo_flag <= 1'b0;
        end else begin
            expire_q <= expire_i;
            if (expire_i && !expire_q) tmo_flag <= 1'b1;
            else if (flag_clr)         tmo_flag <= 1'b0;
        end
    end

    // R3
    open_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q <= OPEN_W'(CFG_OPEN));

    // R2
    tov_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_TOV && open_q == '0) |=> $stable(tov_raw));

    // R4
    upd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_upd |=> !ctl_upd);

    // R12
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !expire_q) |=> tmo_flag);
endmodule

// File: rtl/wdk_counter.sv
// Timeout counter: selects the count source, counts toward the byte-swapped
// limit and compares against the byte-swapped window bound. Assumes tick is
// a one-cycle pulse synchronous to clk.
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        clk_sel,
    input  logic        tick,
    input  logic [15:0] tov_raw,
    input  logic [15:0] win_raw,
    input  logic        service_i,
    output logic        expire_o,
    output logic        early_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tov_eff;
    logic [CNT_W-1:0] win_eff;
    logic             step;

    assign tov_eff = CNT_W'(swap16(tov_raw));
    assign win_eff = CNT_W'(swap16(win_raw));
    assign step    = clk_sel ? tick : 1'b1;

    // Advance the count, clear it on service or while disabled
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (!en || service_i)       cnt_q <= '0;
        else if (step && cnt_q < tov_eff) cnt_q <= cnt_q + 1'b1;
    end

    // Compare the count against the limit and the window bound
    always_comb begin
        expire_o = en && (cnt_q >= tov_eff);
        early_o  = (win_eff != '0) && (cnt_q < win_eff);
    end

    // R7
    service_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        service_i |=> (cnt_q == '0));

    // R6
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && !tick && !service_i) |=> (cnt_q == $past(cnt_q) || cnt_q == '0));
endmodule

// File: rtl/keyed_wdog.sv
// Keyed watchdog top: decodes the register bus, joins the key sequencer,
// configuration registers and counter, and holds the sticky reset request.
// Assumes single-cycle writes and a combinational read path.
module keyed_wdog
    import wdk_pkg::*;
#(
    parameter int KEY_GAP  = 16,
    parameter int CFG_OPEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1k,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              wdog_rst_req
);
    logic        key_wr;
    logic        unlock_p, service_p, key_fault;
    logic        expire, early;
    logic        ctl_en, ctl_upd, ctl_clk, tmo_flag;
    logic [15:0] tov_raw, win_raw;

    assign key_wr = bus_wr && (bus_addr == A_KEY) && (bus_be != 2'b00);

    wdk_key_seq #(.KEY_GAP(KEY_GAP)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_be    (bus_be),
        .key_data  (bus_wdata),
        .early_i   (early),
        .unlock_o  (unlock_p),
        .service_o (service_p),
        .fault_o   (key_fault)
    );

    wdk_cfg_regs #(.CFG_OPEN(CFG_OPEN)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .unlock_i (unlock_p),
        .expire_i (expire),
        .ctl_en   (ctl_en),
        .ctl_upd  (ctl_upd),
        .ctl_clk  (ctl_clk),
        .tov_raw  (tov_raw),
        .win_raw  (win_raw),
        .tmo_flag (tmo_flag)
    );

    wdk_counter #(.CNT_W(16)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_en),
        .clk_sel   (ctl_clk),
        .tick      (tick_1k),
        .tov_raw   (tov_raw),
        .win_raw   (win_raw),
        .service_i (service_p),
        .expire_o  (expire),
        .early_o   (early)
    );

    // Latch any fault or expiry into the sticky reset request
    always_ff @(posedge clk) begin
        if (!rst_n) wdog_rst_req <= 1'b0;
        else        wdog_rst_req <= wdog_rst_req | key_fault | expire;
    end

    // Drive read data for the addressed register
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {13'd0, ctl_clk, ctl_upd, ctl_en};
            A_STAT:  bus_rdata = {15'd0, tmo_flag};
            A_TOV:   bus_rdata = tov_raw;
            A_WIN:   bus_rdata = win_raw;
            default: bus_rdata = 16'h0000;
        endcase
    end

    // R13
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_req |=> wdog_rst_req);

    // R9
    narrow_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_KEY && (bus_be == 2'b01 || bus_be == 2'b10)) |=> wdog_rst_req);

    // R5
    expire_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> wdog_rst_req);
endmodule

// File: tb/keyed_wdog_tb_top.sv
// Directed bench for the keyed watchdog: one task per scenario.
module keyed_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1k = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        wdog_rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit tick_on = 1'b0;
    int tick_div = 0;

    localparam logic [2:0] R_CTRL = 3'd0, R_STAT = 3'd1, R_TOV = 3'd2, R_WIN = 3'd3, R_KEY = 3'd4;

    keyed_wdog dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_1k      (tick_1k),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_be       (bus_be),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wdog_rst_req (wdog_rst_req)
    );

    always #10 clk = ~clk;

    // Tick pulse every ten clocks when enabled
    always @(negedge clk) begin
        if (tick_on) begin
            tick_1k  <= (tick_div == 9);
            tick_div <= (tick_div == 9) ? 0 : tick_div + 1;
        end else begin
            tick_1k  <= 1'b0;
            tick_div <= 0;
        end
    end

    // Watchdog on the run length
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] bswap(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic check_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        bus_be = 2'b00;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic unlock();
        bus_write(R_KEY, 2'b11, 16'h20C5);
        bus_write(R_KEY, 2'b11, 16'h28D9);
    endtask

    task automatic service();
        bus_write(R_KEY, 2'b11, 16'h02A6);
        bus_write(R_KEY, 2'b11, 16'hB480);
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        do_reset();
        check_eq("R1 rst_req", {15'd0, wdog_rst_req}, 16'h0000);
        bus_read(R_CTRL, d); check_eq("R1 ctrl", d, 16'h0002);
        bus_read(R_TOV, d);  check_eq("R1 limit", d, 16'hFFFF);
        bus_read(R_WIN, d);  check_eq("R1 window", d, 16'h0000);
        bus_read(R_STAT, d); check_eq("R1 status", d, 16'h0000);
    endtask

    task automatic t_locked_writes();
        logic [15:0] d;
        do_reset();
        bus_write(R_TOV, 2'b11, 16'h1234);
        bus_read(R_TOV, d); check_eq("R2 write without unlock", d, 16'hFFFF);
        unlock();
        bus_write(R_TOV, 2'b11, 16'h1234);
        bus_read(R_TOV, d); check_eq("R2 write after unlock", d, 16'h1234);
        check_eq("R2 no reset", {15'd0, wdog_rst_req}, 16'h0000);
    endtask

    task automatic t_open_window();
        logic [15:0] d;
        do_reset();
        unlock();
        wait_cyc(135);
        bus_write(R_WIN, 2'b11, 16'h0500);
        bus_read(R_WIN, d); check_eq("R3 write after window", d, 16'h0000);
        check_eq("R3 no reset", {15'd0, wdog_rst_req}, 16'h0000);
    endtask

    task automatic t_update_lock();
        logic [15:0] d;
        do_reset();
        unlock();
        bus_write(R_CTRL, 2'b11, 16'h0000);
        unlock();
        bus_write(R_TOV, 2'b11, 16'h4321);
        bus_read(R_TOV, d);  check_eq("R4 locked limit", d, 16'hFFFF);
        bus_read(R_CTRL, d); check_eq("R4 ctrl", d, 16'h0000);
        check_eq("R4 unlock no reset", {15'd0, wdog_rst_req}, 16'h0000);
    endtask

    task automatic t_timeout_bus();
        logic [15:0] d;
        do_reset();
        unlock();
        bus_write(R_TOV, 2'b11, bswap(16'd40));
        bus_write(R_CTRL, 2'b11, 16'h0003);
        wait_cyc(38);
        check_eq("R5 before limit", {15'd0, wdog_rst_req}, 16'h0000);
        wait_cyc(4);
        check_eq("R5 after limit", {15'd0, wdog_rst_req}, 16'h0001);
        bus_read(R_STAT, d); check_eq("R12 flag set", d, 16'h0001);
        bus_write(R_STAT, 2'b01, 16'h0001);
        bus_read(R_STAT, d); check_eq("R12 flag cleared", d, 16'h0000);
        wait_cyc(10);
        check_eq("R13 request held", {15'd0, wdog_rst_req}, 16'h0001);
    endtask

    task automatic t_unswapped();
        do_reset();
        unlock();
        bus_write(R_TOV, 2'b11, 16'd40);
        bus_write(R_CTRL, 2'b11, 16'h0003);
        wait_cyc(200);
        check_eq("R5 unswapped limit long", {15'd0, wdog_rst_req}, 16'h0000);
    endtask

    task automatic t_tick_source();
        do_reset();
        tick_on = 1'b1;
        unlock();
        bus_write(R_TOV, 2'b11, bswap(16'd5));
        bus_write(R_CTRL, 2'b11, 16'h0007);
        wait_cyc(30);
        check_eq("R6 tick count slow", {15'd0, wdog_rst_req}, 16'h0000);
        wait_cyc(50);
        check_eq("R6 tick expiry", {15'd0, wdog_rst_req}, 16'h0001);
        tick_on = 1'b0;
    endtask

    task automatic t_service();
        do_reset();
        unlock();
        bus_write(R_TOV, 2'b11, bswap(16'd40));
        bus_write(R_CTRL, 2'b11, 16'h0003);
        wait_cyc(30);
        service();
        wait_cyc(30);
        check_eq("R7 service restarts", {15'd0, wdog_rst_req}, 16'h0000);
        wait_cyc(20);
        check_eq("R7 expiry after service", {15'd0, wdog_rst_req}, 16'h0001);
    endtask

    task automatic t_bad_key();
        do_reset();
        bus_write(R_KEY, 2'b11, 16'h1234);
        check_eq("R8 wrong first word", {15'd0, wdog_rst_req}, 16'h0001);
        do_reset();
        bus_write(R_KEY, 2'b11, 16'h20C5);
        bus_write(R_KEY, 2'b11, 16'h28D8);
        check_eq("R8 wrong second word", {15'd0, wdog_rst_req}, 16'h0001);
    endtask

    task automatic t_partial_key();
        do_reset();
        bus_write(R_KEY, 2'b01, 16'h00C5);
        check_eq("R9 narrow key while disabled", {15'd0, wdog_rst_req}, 16'h0001);
    endtask

    task automatic t_key_gap();
        do_reset();
        bus_write(R_KEY, 2'b11, 16'h20C5);
        wait_cyc(8);
        bus_write(R_KEY, 2'b11, 16'h28D9);
        check_eq("R10 second word in time", {15'd0, wdog_rst_req}, 16'h0000);
        do_reset();
        bus_write(R_KEY, 2'b11, 16'h20C5);
        wait_cyc(20);
        check_eq("R10 second word late", {15'd0, wdog_rst_req}, 16'h0001);
    endtask

    task automatic t_window();
        do_reset();
        unlock();
        bus_write(R_TOV, 2'b11, bswap(16'd200));
        bus_write(R_WIN, 2'b11, bswap(16'd20));
        bus_write(R_CTRL, 2'b11, 16'h0003);
        service();
        check_eq("R11 early service", {15'd0, wdog_rst_req}, 16'h0001);
        do_reset();
        unlock();
        bus_write(R_TOV, 2'b11, bswap(16'd200));
        bus_write(R_WIN, 2'b11, bswap(16'd20));
        bus_write(R_CTRL, 2'b11, 16'h0003);
        wait_cyc(40);
        service();
        check_eq("R11 service inside window", {15'd0, wdog_rst_req}, 16'h0000);
    endtask

    initial begin
        t_reset_state();
        t_locked_writes();
        t_open_window();
        t_update_lock();
        t_timeout_bus();
        t_unswapped();
        t_tick_source();
        t_service();
        t_bad_key();
        t_partial_key();
        t_key_gap();
        t_window();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule